// File: doc/BRIEF.md
# Return Address Tamper Guard

This block holds return addresses in hardware and flags a return whose real target differs from the address saved when the matching call was seen. A check request issued just before a call places that call's return address on a speculative stack. A check request issued just before a return removes the top entry, then waits for the execute stage to deliver the computed return target. One cycle after that target arrives, the block raises a one-cycle result strobe together with a mismatch flag. A mismatch means the return address may have been tampered with.

A second, committed stack follows the commit stage. A committed call pushes onto it and a committed return pops it. On a misspeculation the speculative stack is thrown away and replaced, in one cycle, by the committed stack. Both stacks hold `DEPTH` entries of `AW` bits. `DEPTH` must be a power of two. When a stack is full, a push overwrites its oldest entry.

Top module: `ras_guard`

## Requirements
- R1: After reset, ready_o is 1, result_valid_o, mismatch_o and overflow_o are 0, and both stacks are empty.
- R2: When ready_o is 1 and mispredict_i is 0, a call check (call_chk_i=1) pushes call_addr_i onto the speculative stack. A return check (ret_chk_i=1, call_chk_i=0) pops the top entry and holds it for comparison.
- R3: After a return check is accepted, ready_o is 0 from the next cycle until the first cycle in which exe_valid_i is 1. In the cycle after that one, result_valid_o is 1 for exactly one cycle and ready_o is 1 again.
- R4: When result_valid_o is 1, mismatch_o is 1 exactly when exe_target_i differs from the held entry, or when the stack was empty at the time of the check. mismatch_o is 0 whenever result_valid_o is 0.
- R5: A push onto a full stack (DEPTH entries) discards the oldest entry and keeps the newest DEPTH entries. It also sets overflow_o, which stays 1 until reset.
- R6: commit_call_i pushes commit_addr_i onto the committed stack. commit_ret_i pops it. A pop of an empty committed stack has no effect.
- R7: mispredict_i copies the committed stack into the speculative stack, including any commit in the same cycle. It cancels a pending return check without a result, and it ignores checks in that cycle.
- R8: If call_chk_i and ret_chk_i are both 1, only the call check is accepted. Checks presented while ready_o is 0 are ignored.
- R9: If commit_call_i and commit_ret_i are both 1, only the push is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_chk_i | input | 1 | Check request ahead of a call |
| call_addr_i | input | AW | Return address of that call |
| ret_chk_i | input | 1 | Check request ahead of a return |
| exe_valid_i | input | 1 | Execute stage delivers a return target |
| exe_target_i | input | AW | Computed return target |
| commit_call_i | input | 1 | A call commits |
| commit_addr_i | input | AW | Return address of the committed call |
| commit_ret_i | input | 1 | A return commits |
| mispredict_i | input | 1 | Misspeculation: restore speculative stack |
| ready_o | output | 1 | New checks are accepted |
| result_valid_o | output | 1 | One-cycle strobe for a completed return check |
| mismatch_o | output | 1 | Possible tampering, valid with result_valid_o |
| overflow_o | output | 1 | Sticky: a push hit a full stack |

## Verification
Directed sequences cover three kinds of return check: nested calls returned in order with correct targets, the same calls returned with one corrupted target, and a return on an empty stack. Together they separate correct LIFO ordering from a plain compare and from empty handling.

Seventeen pushes in a row check that the oldest entry is discarded at the right point. Commit traffic followed by a misspeculation, issued both with and without a pending return, shows whether the copy uses the committed state from the current cycle or from the previous one. A long seeded random mix of every input, checked against a shift-array model in the bench, exposes wrong priorities between simultaneous requests.

// File: rtl/ras_guard.sv
module ras_guard #(
  parameter int DEPTH = 16,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_chk_i,
  input  logic [AW-1:0] call_addr_i,
  input  logic          ret_chk_i,
  input  logic          exe_valid_i,
  input  logic [AW-1:0] exe_target_i,
  input  logic          commit_call_i,
  input  logic [AW-1:0] commit_addr_i,
  input  logic          commit_ret_i,
  input  logic          mispredict_i,
  output logic          ready_o,
  output logic          result_valid_o,
  output logic          mismatch_o,
  output logic          overflow_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] sh_mem [DEPTH];
  logic [AW-1:0] rl_mem [DEPTH];
  logic [AW-1:0] rl_mem_nx [DEPTH];
  logic [PW-1:0] sh_top, rl_top, rl_top_nx;
  logic [CW-1:0] sh_cnt, rl_cnt, rl_cnt_nx;
  logic          waiting, hold_empty;
  logic [AW-1:0] hold_addr;

  assign ready_o = !waiting;

  wire call_acc = ready_o && call_chk_i && !mispredict_i;
  wire ret_acc  = ready_o && ret_chk_i && !call_chk_i && !mispredict_i;
  wire rl_push  = commit_call_i;
  wire rl_pop   = commit_ret_i && !commit_call_i && (rl_cnt != '0);

  always_comb begin
    rl_mem_nx = rl_mem;
    rl_top_nx = rl_top;
    rl_cnt_nx = rl_cnt;
    if (rl_push) begin
      rl_top_nx            = rl_top + 1'b1;
      rl_mem_nx[rl_top_nx] = commit_addr_i;
      if (rl_cnt != FULL) rl_cnt_nx = rl_cnt + 1'b1;
    end else if (rl_pop) begin
      rl_top_nx = rl_top - 1'b1;
      rl_cnt_nx = rl_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    rl_mem <= rl_mem_nx;
    if (mispredict_i) sh_mem <= rl_mem_nx;
    else if (call_acc) sh_mem[sh_top + 1'b1] <= call_addr_i;
    if (ret_acc) hold_addr <= sh_mem[sh_top];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rl_top         <= '0;
      rl_cnt         <= '0;
      sh_top         <= '0;
      sh_cnt         <= '0;
      waiting        <= 1'b0;
      hold_empty     <= 1'b0;
      result_valid_o <= 1'b0;
      mismatch_o     <= 1'b0;
      overflow_o     <= 1'b0;
    end else begin
      rl_top         <= rl_top_nx;
      rl_cnt         <= rl_cnt_nx;
      result_valid_o <= 1'b0;
      mismatch_o     <= 1'b0;
      if ((call_acc && sh_cnt == FULL) || (rl_push && rl_cnt == FULL))
        overflow_o <= 1'b1;
      if (mispredict_i) begin
        sh_top  <= rl_top_nx;
        sh_cnt  <= rl_cnt_nx;
        waiting <= 1'b0;
      end else if (waiting) begin
        if (exe_valid_i) begin
          waiting        <= 1'b0;
          result_valid_o <= 1'b1;
          mismatch_o     <= hold_empty || (exe_target_i != hold_addr);
        end
      end else if (call_acc) begin
        sh_top <= sh_top + 1'b1;
        if (sh_cnt != FULL) sh_cnt <= sh_cnt + 1'b1;
      end else if (ret_acc) begin
        waiting    <= 1'b1;
        hold_empty <= (sh_cnt == '0);
        if (sh_cnt != '0) begin
          sh_top <= sh_top - 1'b1;
          sh_cnt <= sh_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ras_guard_props.sv
module ras_guard_props (
  input logic clk,
  input logic rst_n,
  input logic call_chk_i,
  input logic ret_chk_i,
  input logic exe_valid_i,
  input logic mispredict_i,
  input logic ready_o,
  input logic result_valid_o,
  input logic mismatch_o,
  input logic overflow_o
);
  p_wait_after_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && ret_chk_i && !call_chk_i && !mispredict_i) |=> !ready_o);

  p_result_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> ($past(exe_valid_i) && !$past(ready_o) && !$past(mispredict_i)));

  p_result_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> ready_o);

  p_mismatch_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_o |-> result_valid_o);

  p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  p_flush_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_i |=> (ready_o && !result_valid_o));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && !exe_valid_i && !mispredict_i) |=> !ready_o);
endmodule

bind ras_guard ras_guard_props u_props (
  .clk(clk), .rst_n(rst_n), .call_chk_i(call_chk_i), .ret_chk_i(ret_chk_i),
  .exe_valid_i(exe_valid_i), .mispredict_i(mispredict_i), .ready_o(ready_o),
  .result_valid_o(result_valid_o), .mismatch_o(mismatch_o), .overflow_o(overflow_o)
);

// File: tb/ras_guard_test.sv
`timescale 1ns/1ps
module ras_guard_test;
  localparam int D = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic call_chk_i = 0, ret_chk_i = 0, exe_valid_i = 0;
  logic commit_call_i = 0, commit_ret_i = 0, mispredict_i = 0;
  logic [31:0] call_addr_i = 0, exe_target_i = 0, commit_addr_i = 0;
  logic ready_o, result_valid_o, mismatch_o, overflow_o;
  int checks = 0, fails = 0;

  logic [31:0] sh [D];
  logic [31:0] rl [D];
  int sh_n = 0, rl_n = 0;
  bit m_wait = 0, m_rv = 0, m_mm = 0, m_ovf = 0, h_empty = 0;
  logic [31:0] h_top = 0;

  ras_guard uut (.*);

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic bit exp_mm(bit e, logic [31:0] top, logic [31:0] t);
    return e || (top != t);
  endfunction

  task automatic compare(string tag);
    checks++;
    if (ready_o !== !m_wait || result_valid_o !== m_rv || mismatch_o !== m_mm || overflow_o !== m_ovf) begin
      fails++;
      $display("FAIL %s: rdy/rv/mm/ovf act=%b%b%b%b exp=%b%b%b%b", tag,
               ready_o, result_valid_o, mismatch_o, overflow_o, !m_wait, m_rv, m_mm, m_ovf);
    end
  endtask

  task automatic cyc(bit c, logic [31:0] ca, bit r, bit ev, logic [31:0] t,
                     bit cc, logic [31:0] cca, bit cr, bit mp, string tag);
    call_chk_i = c; call_addr_i = ca; ret_chk_i = r; exe_valid_i = ev; exe_target_i = t;
    commit_call_i = cc; commit_addr_i = cca; commit_ret_i = cr; mispredict_i = mp;
    m_rv = 0; m_mm = 0;
    if (cc) begin
      if (rl_n == D) begin
        for (int i = 0; i < D-1; i++) rl[i] = rl[i+1];
        rl[D-1] = cca; m_ovf = 1;
      end else begin rl[rl_n] = cca; rl_n++; end
    end else if (cr && rl_n > 0) rl_n--;
    if (mp) begin
      for (int i = 0; i < D; i++) sh[i] = rl[i];
      sh_n = rl_n; m_wait = 0;
    end else if (m_wait) begin
      if (ev) begin m_rv = 1; m_mm = exp_mm(h_empty, h_top, t); m_wait = 0; end
    end else if (c) begin
      if (sh_n == D) begin
        for (int i = 0; i < D-1; i++) sh[i] = sh[i+1];
        sh[D-1] = ca; m_ovf = 1;
      end else begin sh[sh_n] = ca; sh_n++; end
    end else if (r) begin
      h_empty = (sh_n == 0);
      h_top = (sh_n == 0) ? 32'h0 : sh[sh_n-1];
      if (sh_n > 0) sh_n--;
      m_wait = 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic ret_pair(logic [31:0] t, string tag);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, tag);
    cyc(0, 0, 0, 1, t, 0, 0, 0, 0, tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (ready_o !== 1 || result_valid_o !== 0 || mismatch_o !== 0 || overflow_o !== 0) begin
      fails++;
      $display("FAIL R1: reset outputs act=%b%b%b%b exp=1000", ready_o, result_valid_o, mismatch_o, overflow_o);
    end
    // R4 empty stack return
    ret_pair(32'h0, "R4_empty");
    // R2 nested calls, in-order returns
    cyc(1, 32'h100, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 32'h200, 0, 0, 0, 0, 0, 0, 0, "R2");
    cyc(1, 32'h300, 0, 0, 0, 0, 0, 0, 0, "R2");
    ret_pair(32'h300, "R2");
    ret_pair(32'h2FF, "R4_bad_target");
    ret_pair(32'h100, "R2");
    // R3 long wait with checks ignored while busy (R8)
    cyc(1, 32'hA0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3");
    cyc(1, 32'hBAD, 0, 0, 0, 0, 0, 0, 0, "R8_busy");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R8_busy");
    cyc(0, 0, 0, 1, 32'hA0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    ret_pair(32'h0, "R8_busy_empty");
    // R8 simultaneous call+ret
    cyc(1, 32'h55, 1, 0, 0, 0, 0, 0, 0, "R8_both");
    ret_pair(32'h55, "R8_both");
    // R5 overflow on speculative stack
    for (int i = 0; i < D+1; i++) cyc(1, 32'h1000 + i, 0, 0, 0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < D; i++) ret_pair(32'h1000 + D - i, "R5_keep");
    ret_pair(32'h0, "R5_empty_after");
    // R6/R9 commit path then R7 restore
    cyc(0, 0, 0, 0, 0, 1, 32'h700, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 32'h800, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1, 32'h900, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
    cyc(1, 32'hDEAD, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 32'h800, 1, 32'hC00, 0, 1, "R7_cancel");
    ret_pair(32'hC00, "R7_same_cycle");
    ret_pair(32'h800, "R7");
    ret_pair(32'h700, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6_empty_pop");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R6_empty_pop");
    ret_pair(32'h0, "R6_empty_pop");
    // random mix
    begin
      int unsigned seed = 32'd12345;
      void'($urandom(seed));
      for (int k = 0; k < 4000; k++) begin
        bit c = ($urandom % 3) == 0;
        bit r = ($urandom % 3) == 0;
        bit ev = ($urandom % 2) == 0;
        bit cc = ($urandom % 4) == 0;
        bit cr = ($urandom % 4) == 0;
        bit mp = ($urandom % 25) == 0;
        logic [31:0] a = 32'h40 + ($urandom % 8);
        logic [31:0] t = (m_wait && ($urandom % 4) != 0) ? h_top : 32'h40 + ($urandom % 8);
        cyc(c, a, r, ev, t, cc, 32'h40 + ($urandom % 8), cr, mp, "R2_R4_R7_random");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule